// File: doc/BRIEF.md
# DTMF Tone Period Detector

This block turns two squared-up telephone tones into a key code. One input carries the low-group (row) tone and the other the high-group (column) tone, both as logic-level square waves. Each input passes through a two-stage synchronizer. The block counts clock cycles between successive rising edges to get the tone period. It then matches that period against the four acceptance bands of its group.

A group counts as valid once several consecutive periods land in the same band. When both groups are valid, the block raises `detect` and shows the 2-bit row and column addresses. One cycle later, a key encoder turns the pair into a 4-bit code and raises `key_valid`. `early_steer` is high only while `detect` and `key_valid` are both high. A period outside every band drops validity at once, and so does a tone that stops toggling.

The clock rate is a parameter, 4.194304 MHz by default. All band limits and timeouts are derived from it.

Top module: `dtmf_period_detector`

## Requirements
- R1: While `rst_n` is low, `detect`, `row_addr`, `col_addr`, `key_valid`, `key_code` and `early_steer` are all 0.
- R2: A row period of P cycles falls in band i (address i = 0,1,2,3 for 697, 770, 852 and 941 Hz) when P·f·1025 ≥ CLK_HZ·1000 and P·f·975 ≤ CLK_HZ·1000.
- R3: A column period falls in band i (address i = 0,1,2,3 for 1209, 1336, 1477 and 1633 Hz) under the same rule as R2.
- R4: The period is the number of clock edges between two rising edges of the input after a two-flop synchronizer. A group becomes valid at the edge that measures its CONFIRM-th (default 4) consecutive period in the same band, and it stays valid while further periods stay in that band.
- R5: `detect` goes high one cycle after both groups are valid. A measured period that is in no band, or in a different band, drops that group's validity at that edge.
- R6: If a group sees no rising edge for TIMEOUT cycles, its validity clears. TIMEOUT is L + L/8, where L is the longest period accepted in the group's lowest band.
- R7: `key_code` follows the keypad: digits 1–9 give 1–9, digit 0 gives 10, * gives 11, # gives 12, and A, B, C, D give 13, 14, 15, 0. The keypad rows are 1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D and the columns are in band order.
- R8: `key_valid` is `detect` delayed by one cycle. `key_code` is the code of `row_addr`/`col_addr` as they were one cycle earlier.
- R9: `early_steer` is high exactly when `detect` and `key_valid` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_tone | input | 1 | Squared low-group tone |
| col_tone | input | 1 | Squared high-group tone |
| detect | output | 1 | Both tones confirmed in band |
| row_addr | output | 2 | Band address of the row tone |
| col_addr | output | 2 | Band address of the column tone |
| key_valid | output | 1 | Encoder enable, one cycle after detect |
| key_code | output | 4 | Encoded key |
| early_steer | output | 1 | Valid tone pair received |

## Verification
The hardest cases to reach are the band edges. One period more or less at a band limit must flip acceptance, and a synchronized edge lands a whole number of cycles after the driven one. The bench gets there by running the square-wave generators with chosen integer periods: the exact lower and upper accepted periods of a row band and the values just outside them. A behavioural model follows every edge, so the cycle where validity appears or drops is checked and not only the steady result. Tone dropout is produced by stopping one generator mid-pair. The check is that the steering output falls only after the timeout window.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  // Nominal tone frequency for a group (0 = row, 1 = column) and band address.
  function automatic longint tone_hz(bit high_grp, logic [1:0] idx);
    case ({high_grp, idx})
      3'b000:  return 697;
      3'b001:  return 770;
      3'b010:  return 852;
      3'b011:  return 941;
      3'b100:  return 1209;
      3'b101:  return 1336;
      3'b110:  return 1477;
      default: return 1633;
    endcase
  endfunction

  // Shortest accepted period: tone at +2.5 %, rounded up.
  function automatic longint band_lo(longint clk_hz, longint f);
    return (clk_hz * 1000 + f * 1025 - 1) / (f * 1025);
  endfunction

  // Longest accepted period: tone at -2.5 %, rounded down.
  function automatic longint band_hi(longint clk_hz, longint f);
    return (clk_hz * 1000) / (f * 975);
  endfunction

  // Keypad position to 4-bit code.
  function automatic logic [3:0] key_of(logic [1:0] r, logic [1:0] c);
    if (c == 2'd3)      return 4'(13 + r);           // A B C D -> 13 14 15 0
    else if (r != 2'd3) return 4'(3 * r + c + 1);    // 1..9
    else begin
      case (c)
        2'd0:    return 4'd11;                       // *
        2'd1:    return 4'd10;                       // 0
        default: return 4'd12;                       // #
      endcase
    end
  endfunction

endpackage

// File: rtl/dtmf_tone_meter.sv
module dtmf_tone_meter #(
  parameter longint CLK_HZ     = 4194304,
  parameter bit     HIGH_GROUP = 1'b0,
  parameter int     CONFIRM    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_in,
  output logic       valid,
  output logic [1:0] band
);
  import dtmf_pkg::*;

  localparam int unsigned LONGEST = 32'(band_hi(CLK_HZ, tone_hz(HIGH_GROUP, 2'd0)));
  localparam int unsigned TIMEOUT = LONGEST + LONGEST / 8;
  localparam int          CW      = $clog2(TIMEOUT + 1);
  localparam int          RW      = $clog2(CONFIRM + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(TIMEOUT);
  localparam logic [RW-1:0] RUN_MAX = RW'(CONFIRM);

  logic [1:0]    sync;
  logic          prev;
  logic [CW-1:0] cnt;
  logic [RW-1:0] run;
  logic [1:0]    last;
  logic [3:0]    in_band;

  // named internal events
  logic       rise_evt;
  logic       period_hit;
  logic [1:0] hit_idx;
  logic       timeout_evt;

  assign rise_evt    = sync[1] & ~prev;
  assign timeout_evt = ~rise_evt && (cnt == CNT_SAT);

  for (genvar b = 0; b < 4; b++) begin : band_g
    localparam longint        F  = tone_hz(HIGH_GROUP, 2'(b));
    localparam logic [CW-1:0] LO = CW'(band_lo(CLK_HZ, F));
    localparam logic [CW-1:0] HI = CW'(band_hi(CLK_HZ, F));
    assign in_band[b] = (cnt >= LO) && (cnt <= HI);
  end

  always_comb begin
    period_hit = |in_band;
    hit_idx    = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (in_band[i]) hit_idx = 2'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b00;
      prev <= 1'b0;
      cnt  <= CNT_SAT;
      run  <= '0;
      last <= 2'd0;
    end else begin
      sync <= {sync[0], tone_in};
      prev <= sync[1];
      if (rise_evt)            cnt <= CW'(1);
      else if (cnt != CNT_SAT) cnt <= cnt + 1'b1;

      if (rise_evt) begin
        if (period_hit) begin
          last <= hit_idx;
          if (hit_idx == last && run != '0)
            run <= (run == RUN_MAX) ? run : run + 1'b1;
          else
            run <= RW'(1);
        end else begin
          run <= '0;
        end
      end else if (timeout_evt) begin
        run <= '0;
      end
    end
  end

  assign valid = (run == RUN_MAX);
  assign band  = last;

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_MAX); // R4
  AST_VALID_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(rise_evt && period_hit)); // R4
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !period_hit) |=> !valid); // R5
  AST_SILENCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !valid); // R6

endmodule

// File: rtl/dtmf_key_encoder.sv
module dtmf_key_encoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pair_ok,
  input  logic [1:0] row,
  input  logic [1:0] col,
  output logic       enable,
  output logic [3:0] code
);
  import dtmf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      code   <= 4'd0;
    end else begin
      enable <= pair_ok;
      code   <= key_of(row, col);
    end
  end

  AST_ENABLE_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> $past(pair_ok)); // R8

endmodule

// File: rtl/dtmf_period_detector.sv
module dtmf_period_detector #(
  parameter longint CLK_HZ  = 4194304,
  parameter int     CONFIRM = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_tone,
  input  logic       col_tone,
  output logic       detect,
  output logic [1:0] row_addr,
  output logic [1:0] col_addr,
  output logic       key_valid,
  output logic [3:0] key_code,
  output logic       early_steer
);
  logic [1:0] tones;
  logic [1:0] grp_valid;
  logic [1:0] grp_band [2];

  assign tones = {col_tone, row_tone};

  for (genvar g = 0; g < 2; g++) begin : grp
    dtmf_tone_meter #(
      .CLK_HZ    (CLK_HZ),
      .HIGH_GROUP(g == 1),
      .CONFIRM   (CONFIRM)
    ) u_meter (
      .clk    (clk),
      .rst_n  (rst_n),
      .tone_in(tones[g]),
      .valid  (grp_valid[g]),
      .band   (grp_band[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      detect   <= 1'b0;
      row_addr <= 2'd0;
      col_addr <= 2'd0;
    end else begin
      detect   <= &grp_valid;
      row_addr <= grp_band[0];
      col_addr <= grp_band[1];
    end
  end

  dtmf_key_encoder u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .pair_ok(detect),
    .row    (row_addr),
    .col    (col_addr),
    .enable (key_valid),
    .code   (key_code)
  );

  assign early_steer = detect & key_valid;

  AST_STEER_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    early_steer |-> $past(detect)); // R9
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (early_steer && $past(early_steer)) |-> $stable(key_code)); // R7
  AST_DETECT_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && $past(detect)) |-> ($stable(row_addr) && $stable(col_addr))); // R5

endmodule

// File: tb/dtmf_period_detector_test.sv
module dtmf_period_detector_test;
  localparam longint CLK_HZ  = 262144;
  localparam int     CONFIRM = 4;
  localparam string  PAD     = "123A456B789C*0#D";

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_tone = 1'b0;
  logic col_tone = 1'b0;
  logic detect, key_valid, early_steer;
  logic [1:0] row_addr, col_addr;
  logic [3:0] key_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int row_per = 0;
  int col_per = 0;
  int rph = 0;
  int cph = 0;

  always #2.5 clk = ~clk;

  dtmf_period_detector #(.CLK_HZ(CLK_HZ), .CONFIRM(CONFIRM)) uut (
    .clk(clk), .rst_n(rst_n), .row_tone(row_tone), .col_tone(col_tone),
    .detect(detect), .row_addr(row_addr), .col_addr(col_addr),
    .key_valid(key_valid), .key_code(key_code), .early_steer(early_steer)
  );

  function automatic longint freq(int g, int i);
    longint rows [4] = '{697, 770, 852, 941};
    longint cols [4] = '{1209, 1336, 1477, 1633};
    return (g == 0) ? rows[i] : cols[i];
  endfunction

  function automatic int band_of(int g, int p);
    for (int i = 0; i < 4; i++) begin
      if (longint'(p) * freq(g, i) * 1025 >= CLK_HZ * 1000 &&
          longint'(p) * freq(g, i) * 975 <= CLK_HZ * 1000) return i;
    end
    return -1;
  endfunction

  function automatic int tmo(int g);
    int l;
    l = int'((CLK_HZ * 1000) / (freq(g, 0) * 975));
    return l + l / 8;
  endfunction

  function automatic int code_of(byte ch);
    if (ch >= "1" && ch <= "9") return ch - "0";
    case (ch)
      "0": return 10;
      "*": return 11;
      "#": return 12;
      "A": return 13;
      "B": return 14;
      "C": return 15;
      default: return 0;
    endcase
  endfunction

  // ---------------- reference model ----------------
  int  k;
  bit  h1 [2], h2 [2], h3 [2];
  int  last_rise [2];
  int  win [2][4];
  int  filled [2];
  int  mlast [2];
  bit  mvalid [2];
  bit  m_det, m_en;
  int  m_row, m_col, m_code;

  task automatic model_reset();
    k = 0;
    for (int g = 0; g < 2; g++) begin
      h1[g] = 0; h2[g] = 0; h3[g] = 0;
      last_rise[g] = -1000000; filled[g] = 0; mlast[g] = 0; mvalid[g] = 0;
      for (int j = 0; j < 4; j++) win[g][j] = -1;
    end
    m_det = 0; m_en = 0; m_row = 0; m_col = 0; m_code = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit n_det, n_en;
      int n_row, n_col, n_code;
      n_det  = mvalid[0] && mvalid[1];
      n_en   = m_det;
      n_code = code_of(PAD[m_row * 4 + m_col]);
      n_row  = mlast[0];
      n_col  = mlast[1];
      for (int g = 0; g < 2; g++) begin
        bit cur, rose;
        int gap;
        cur  = (g == 0) ? row_tone : col_tone;
        rose = h2[g] && !h3[g];
        gap  = k - last_rise[g];
        if (gap > tmo(g)) gap = tmo(g);
        if (rose) begin
          int b;
          b = band_of(g, gap);
          for (int j = 3; j > 0; j--) win[g][j] = win[g][j-1];
          win[g][0] = b;
          if (filled[g] < 4) filled[g]++;
          last_rise[g] = k;
          if (b >= 0) mlast[g] = b;
        end else if (gap >= tmo(g)) begin
          filled[g] = 0;
        end
        mvalid[g] = (filled[g] == 4) && (win[g][0] >= 0) &&
                    (win[g][0] == win[g][1]) && (win[g][1] == win[g][2]) &&
                    (win[g][2] == win[g][3]);
        h3[g] = h2[g]; h2[g] = h1[g]; h1[g] = cur;
      end
      m_det = n_det; m_en = n_en; m_row = n_row; m_col = n_col; m_code = n_code;
      k++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison and stimulus, away from the active edge
  always @(negedge clk) begin
    cycles++;
    check(detect == m_det,             "R5 detect",      detect,      m_det);
    check(row_addr == 2'(m_row),       "R2 row_addr",    row_addr,    m_row);
    check(col_addr == 2'(m_col),       "R3 col_addr",    col_addr,    m_col);
    check(key_valid == m_en,           "R8 key_valid",   key_valid,   m_en);
    check(key_code == 4'(m_code),      "R7 key_code",    key_code,    m_code);
    check(early_steer == (m_det && m_en), "R9 early_steer", early_steer, m_det && m_en);
    if (row_per == 0) begin rph = 0; row_tone = 0; end
    else begin rph = (rph + 1 >= row_per) ? 0 : rph + 1; row_tone = (rph < row_per / 2); end
    if (col_per == 0) begin cph = 0; col_tone = 0; end
    else begin cph = (cph + 1 >= col_per) ? 0 : cph + 1; col_tone = (cph < col_per / 2); end
  end

  function automatic int nominal(int g, int i);
    return int'((CLK_HZ + freq(g, i) / 2) / freq(g, i));
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_key(byte ch);
    int pos, r, c, rp, cp;
    pos = -1;
    for (int i = 0; i < 16; i++) if (PAD[i] == ch) pos = i;
    r = pos / 4; c = pos % 4;
    rp = nominal(0, r); cp = nominal(1, c);
    row_per = rp; col_per = cp;
    wait_cyc(7 * rp + 8);
    check(early_steer == 1,      "R9 steer on key",  early_steer, 1);
    check(detect == 1,           "R5 detect on key", detect, 1);
    check(row_addr == 2'(r),     "R2 row address",   row_addr, r);
    check(col_addr == 2'(c),     "R3 col address",   col_addr, c);
    check(key_code == 4'(code_of(ch)), "R7 key code", key_code, code_of(ch));
  endtask

  task automatic row_edge(int rp, bit expect_on, string req);
    row_per = rp; col_per = nominal(1, 0);
    wait_cyc(7 * rp + 8);
    check(detect == expect_on, req, detect, expect_on);
  endtask

  initial begin
    wait_cyc(4);
    // R1: reset values
    check(detect == 0 && key_valid == 0 && early_steer == 0, "R1 flags in reset",
          {detect, key_valid, early_steer}, 0);
    check(row_addr == 0 && col_addr == 0 && key_code == 0, "R1 fields in reset",
          {row_addr, col_addr, key_code}, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    check(early_steer == 0, "R4 no tones no steer", early_steer, 0);

    run_key("1"); run_key("5"); run_key("9"); run_key("0");
    run_key("*"); run_key("#"); run_key("A"); run_key("C");
    run_key("D"); run_key("B");

    // R2 band limits for 697 Hz at this clock: 367..385 accepted
    row_edge(367, 1'b1, "R2 lower limit accepted");
    row_edge(366, 1'b0, "R2 below lower limit rejected");
    row_edge(385, 1'b1, "R2 upper limit accepted");
    row_edge(386, 1'b0, "R2 above upper limit rejected");

    // R3 column outside all bands
    row_per = nominal(0, 1); col_per = 200 + 0;
    col_per = 205;
    wait_cyc(7 * row_per + 8);
    check(detect == 0, "R3 column gap rejected", detect, 0);

    // R6 dropout: steady key then stop column
    run_key("6");
    col_per = 0;
    wait_cyc(tmo(1) / 2);
    check(early_steer == 1, "R6 held inside timeout", early_steer, 1);
    wait_cyc(tmo(1) + 8);
    check(early_steer == 0, "R6 dropped after timeout", early_steer, 0);
    check(detect == 0, "R6 detect dropped", detect, 0);

    // R4 reconfirm after silence
    col_per = nominal(1, 2);
    wait_cyc(2 * col_per);
    check(detect == 0, "R4 not yet confirmed", detect, 0);
    wait_cyc(6 * row_per);
    check(early_steer == 1 && key_code == 4'd6, "R4 confirmed again", key_code, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule